// File: doc/BRIEF.md
# In-Order Commit Instruction Window

This block is the out-of-order core of a simple dynamically scheduled pipeline. It holds up to eight in-flight instructions in a circular queue. Each slot is both a waiting station and a reorder slot. The decoder writes one instruction per cycle at the tail. Each source is either a value or a register tag still to be produced.

Waiting sources watch two buses. One is the result bus driven by the functional units. The other is the block's own commit bus, which carries results retiring in order to the register file. A value that has finished executing but has not yet retired is therefore still caught, without any search logic.

Each cycle the block does four things at once:
- It offers at most one fully ready instruction to the functional units. Memory operations come first, then the oldest.
- It records results that come back by slot number.
- It retires the head instruction once that instruction has executed, which keeps register state precise.
- It accepts one new instruction.

A flush drops every uncommitted instruction.

Top module: `commit_window`

## Requirements
- R1: After reset the window is empty: `alloc_ready` is 1, `cmt_valid` is 0 and `disp_valid` is 0.
- R2: The window holds at most DEPTH (8) instructions. `alloc_ready` is 0 exactly when DEPTH instructions are held, and an `alloc_valid` while it is 0 is ignored. Slot numbers on `alloc_slot` count up from 0 after reset or flush and wrap modulo DEPTH.
- R3: Instructions retire on `cmt_valid` strictly in allocation order. The head retires in the first cycle after its result has been received, and a younger executed entry waits behind an unexecuted head.
- R4: A retirement presents the entry's destination tag on `cmt_tag`, the data received on the result bus on `cmt_data`, and its program counter on `cmt_pc`.
- R5: `disp_valid` is 1 only for an entry that is not yet dispatched and has both sources ready. The dispatch port shows that entry's slot, opcode, memory flag, destination tag and both source values.
- R6: At most one entry is dispatched per cycle (`disp_valid` and `disp_ready` both 1), and no entry is offered again after it was dispatched.
- R7: Among the dispatchable entries, one with `alloc_mem` set wins over any without it. Within the same class, the entry allocated earliest wins.
- R8: A waiting source whose tag equals `res_tag` while `res_valid` is 1 captures `res_data` and becomes ready in the next cycle.
- R9: A waiting source whose tag equals the tag of a retirement in progress captures `cmt_data` and becomes ready in the next cycle.
- R10: A source allocated not ready, whose tag matches the result bus or the commit bus in the allocation cycle, is stored as ready with that data.
- R11: `flush` empties the window in the next cycle, discarding every uncommitted instruction and any allocation in the same cycle. Numbering of slots restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all held instructions |
| alloc_valid | input | 1 | Decoder offers an instruction |
| alloc_ready | output | 1 | Window has a free slot |
| alloc_slot | output | 3 | Slot the offered instruction will occupy |
| alloc_pc | input | 16 | Program counter of the instruction |
| alloc_op | input | 4 | Opcode passed through to the dispatch port |
| alloc_mem | input | 1 | Instruction is a load or store |
| alloc_dst | input | 8 | Destination register tag |
| alloc_a_rdy | input | 1 | Source A holds a value |
| alloc_a_tag | input | 8 | Source A producer tag when not ready |
| alloc_a_data | input | 16 | Source A value when ready |
| alloc_b_rdy | input | 1 | Source B holds a value |
| alloc_b_tag | input | 8 | Source B producer tag when not ready |
| alloc_b_data | input | 16 | Source B value when ready |
| disp_valid | output | 1 | An instruction is offered to the functional units |
| disp_ready | input | 1 | Functional units take the offered instruction |
| disp_slot | output | 3 | Slot of the offered instruction |
| disp_op | output | 4 | Opcode |
| disp_mem | output | 1 | Memory-operation flag |
| disp_a | output | 16 | Source A value |
| disp_b | output | 16 | Source B value |
| disp_dst | output | 8 | Destination tag |
| res_valid | input | 1 | Result bus carries a result |
| res_slot | input | 3 | Slot whose instruction produced the result |
| res_tag | input | 8 | Destination tag of the result |
| res_data | input | 16 | Result value |
| cmt_valid | output | 1 | Head instruction retires this cycle |
| cmt_tag | output | 8 | Destination tag being written |
| cmt_data | output | 16 | Value being written |
| cmt_pc | output | 16 | Program counter of the retiring instruction |

## Verification
The assertions run on every cycle and check local properties. Pointer occupancy never exceeds the queue and never underflows. The grant always lands on a requesting slot, and on a memory slot whenever one requests. A ready source holds its value, and a waiting source captures a matching result. A head that has just executed retires next cycle, a dispatched slot is never offered twice, and a flush leaves the window empty.

Other behaviour is only visible end to end, and only the bench scenarios can show it. This covers retirement order across out-of-order completion, the values that flow through commit-bus and same-cycle captures, refusal of allocation when full, and recovery from flushes. The bench shows these by comparing every output against a behavioural queue model each cycle, across phases that fill, balance, drain and favour memory traffic.

// File: rtl/cw_pkg.sv
// Shared types of the in-order commit window.
package cw_pkg;

    // Which rule decided the dispatch grant this cycle.
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_MEM  = 2'd1,
        PICK_AGE  = 2'd2
    } pick_kind_e;

endpackage

// File: rtl/cw_ptrs.sv
// Head/tail pointers and occupancy count of the circular window.
// Assumes DEPTH is a power of two so that the pointers wrap naturally.
// push must only be raised when not full and pop only when not empty.
module cw_ptrs #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full
);

    logic [CNT_W-1:0] count;
    logic             empty;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // Advance pointers and count; reset and flush return to an empty queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + 1'b1;
            if (pop)  head <= head + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_gap_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tail - head) == count[IDX_W-1:0]);

endmodule

// File: rtl/cw_operand.sv
// One source-operand cell: ready bit, producer tag and value.
// While waiting it compares its tag against the result bus and the commit
// bus and captures on a match. On load the incoming tag is compared
// directly, so a producer finishing in the same cycle is not missed.
// Assumes at most one bus carries a given tag in a cycle.
module cw_operand #(
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              in_rdy,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    input  logic              res_vld,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic              cmt_vld,
    input  logic [TAG_W-1:0]  cmt_tag,
    input  logic [DATA_W-1:0] cmt_data,
    output logic              rdy,
    output logic [DATA_W-1:0] data
);

    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] key;
    logic             hit_res;
    logic             hit_cmt;

    // Tag under comparison: the incoming one on load, else the stored one.
    always_comb begin
        key     = load ? in_tag : tag_q;
        hit_res = res_vld && (res_tag == key);
        hit_cmt = cmt_vld && (cmt_tag == key);
    end

    // Load a new source, or capture a matching broadcast while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy   <= 1'b0;
            tag_q <= '0;
            data  <= '0;
        end else if (clear) begin
            rdy <= 1'b0;
        end else if (load) begin
            tag_q <= in_tag;
            if (in_rdy) begin
                rdy  <= 1'b1;
                data <= in_data;
            end else if (hit_res) begin
                rdy  <= 1'b1;
                data <= res_data;
            end else if (hit_cmt) begin
                rdy  <= 1'b1;
                data <= cmt_data;
            end else begin
                rdy <= 1'b0;
            end
        end else if (!rdy) begin
            if (hit_res) begin
                rdy  <= 1'b1;
                data <= res_data;
            end else if (hit_cmt) begin
                rdy  <= 1'b1;
                data <= cmt_data;
            end
        end
    end

    p_hold_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !load && !clear) |=> (rdy && $stable(data)));
    p_capture_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !load && !clear && res_vld && res_tag == tag_q)
        |=> (rdy && data == $past(res_data)));
    p_capture_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !load && !clear && !(res_vld && res_tag == tag_q)
         && cmt_vld && cmt_tag == tag_q)
        |=> (rdy && data == $past(cmt_data)));

endmodule

// File: rtl/cw_pick.sv
// Dispatch selector: scans slots in age order starting at the head.
// The oldest requesting memory slot wins; otherwise the oldest requester.
// Assumes DEPTH is a power of two (the slot index wraps on overflow).
module cw_pick
    import cw_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] req,
    input  logic [DEPTH-1:0] mem,
    input  logic [IDX_W-1:0] base,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);

    pick_kind_e       kind;
    logic [IDX_W-1:0] idx_mem;
    logic [IDX_W-1:0] idx_any;
    logic             found_mem;
    logic             found_any;

    // Walk youngest to oldest so the oldest hit is the one that remains.
    always_comb begin
        found_mem = 1'b0;
        found_any = 1'b0;
        idx_mem   = '0;
        idx_any   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            logic [IDX_W-1:0] slot;
            slot = base + IDX_W'(i);
            if (req[slot]) begin
                found_any = 1'b1;
                idx_any   = slot;
                if (mem[slot]) begin
                    found_mem = 1'b1;
                    idx_mem   = slot;
                end
            end
        end
    end

    // Resolve the class of the winner and drive the grant.
    always_comb begin
        if (found_mem)      kind = PICK_MEM;
        else if (found_any) kind = PICK_AGE;
        else                kind = PICK_NONE;
        gnt_vld = (kind != PICK_NONE);
        gnt_idx = (kind == PICK_MEM) ? idx_mem : idx_any;
    end

    p_grant_requested_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> req[gnt_idx]);
    p_grant_when_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> gnt_vld);
    p_memory_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req & mem)) |-> mem[gnt_idx]);

endmodule

// File: rtl/commit_window.sv
// In-order commit instruction window. A circular queue of DEPTH slots, each
// a waiting station and a reorder slot at once. Allocates at the tail,
// dispatches one ready slot, records results by slot, and retires the head
// once it has executed. Waiting sources snoop both the result bus and the
// retirement bus. Assumes DEPTH is a power of two, destination tags in
// flight are unique, and results arrive only for dispatched slots.
module commit_window #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 8,
    parameter int PC_W   = 16,
    parameter int OP_W   = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_slot,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic              alloc_mem,
    input  logic [TAG_W-1:0]  alloc_dst,
    input  logic              alloc_a_rdy,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic [DATA_W-1:0] alloc_a_data,
    input  logic              alloc_b_rdy,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic [DATA_W-1:0] alloc_b_data,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [IDX_W-1:0]  disp_slot,
    output logic [OP_W-1:0]   disp_op,
    output logic              disp_mem,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_dst,
    input  logic              res_valid,
    input  logic [IDX_W-1:0]  res_slot,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic              cmt_valid,
    output logic [TAG_W-1:0]  cmt_tag,
    output logic [DATA_W-1:0] cmt_data,
    output logic [PC_W-1:0]   cmt_pc
);

    logic [IDX_W-1:0]  head;
    logic [IDX_W-1:0]  tail;
    logic              full;
    logic              push;
    logic              pop;
    logic              fire;

    logic [DEPTH-1:0]  ent_vld;
    logic [DEPTH-1:0]  ent_exe;
    logic [DEPTH-1:0]  ent_sent;
    logic [DEPTH-1:0]  ent_mem;
    logic [PC_W-1:0]   ent_pc  [DEPTH];
    logic [OP_W-1:0]   ent_op  [DEPTH];
    logic [TAG_W-1:0]  ent_dst [DEPTH];
    logic [DATA_W-1:0] ent_val [DEPTH];

    logic [DEPTH-1:0]  a_rdy;
    logic [DEPTH-1:0]  b_rdy;
    logic [DATA_W-1:0] a_data [DEPTH];
    logic [DATA_W-1:0] b_data [DEPTH];
    logic [DEPTH-1:0]  req;
    logic              gnt_vld;
    logic [IDX_W-1:0]  gnt_idx;

    // Edge handshakes: accept when room, retire an executed head.
    always_comb begin
        alloc_ready = !full;
        alloc_slot  = tail;
        push        = alloc_valid && !full && !flush;
        cmt_valid   = ent_vld[head] && ent_exe[head];
        cmt_tag     = ent_dst[head];
        cmt_data    = ent_val[head];
        cmt_pc      = ent_pc[head];
        pop         = cmt_valid && !flush;
        fire        = disp_valid && disp_ready;
    end

    cw_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .full  (full)
    );

    // Per-slot control and payload: allocate, mark dispatch, record result, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld  <= '0;
            ent_exe  <= '0;
            ent_sent <= '0;
            ent_mem  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_pc[i]  <= '0;
                ent_op[i]  <= '0;
                ent_dst[i] <= '0;
                ent_val[i] <= '0;
            end
        end else if (flush) begin
            ent_vld  <= '0;
            ent_exe  <= '0;
            ent_sent <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && tail == IDX_W'(i)) begin
                    ent_vld[i]  <= 1'b1;
                    ent_exe[i]  <= 1'b0;
                    ent_sent[i] <= 1'b0;
                    ent_mem[i]  <= alloc_mem;
                    ent_pc[i]   <= alloc_pc;
                    ent_op[i]   <= alloc_op;
                    ent_dst[i]  <= alloc_dst;
                end else begin
                    if (pop && head == IDX_W'(i))
                        ent_vld[i] <= 1'b0;
                    if (fire && disp_slot == IDX_W'(i))
                        ent_sent[i] <= 1'b1;
                    if (res_valid && res_slot == IDX_W'(i) && ent_vld[i]) begin
                        ent_exe[i] <= 1'b1;
                        ent_val[i] <= res_data;
                    end
                end
            end
        end
    end

    // Two snooping source cells per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic load_g;
        assign load_g = push && (tail == IDX_W'(g));

        cw_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_a (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (flush),
            .load     (load_g),
            .in_rdy   (alloc_a_rdy),
            .in_tag   (alloc_a_tag),
            .in_data  (alloc_a_data),
            .res_vld  (res_valid),
            .res_tag  (res_tag),
            .res_data (res_data),
            .cmt_vld  (cmt_valid),
            .cmt_tag  (cmt_tag),
            .cmt_data (cmt_data),
            .rdy      (a_rdy[g]),
            .data     (a_data[g])
        );

        cw_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_b (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (flush),
            .load     (load_g),
            .in_rdy   (alloc_b_rdy),
            .in_tag   (alloc_b_tag),
            .in_data  (alloc_b_data),
            .res_vld  (res_valid),
            .res_tag  (res_tag),
            .res_data (res_data),
            .cmt_vld  (cmt_valid),
            .cmt_tag  (cmt_tag),
            .cmt_data (cmt_data),
            .rdy      (b_rdy[g]),
            .data     (b_data[g])
        );

        assign req[g] = ent_vld[g] && !ent_sent[g] && a_rdy[g] && b_rdy[g];
    end

    cw_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .mem     (ent_mem),
        .base    (head),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    // Present the granted slot on the dispatch port.
    always_comb begin
        disp_valid = gnt_vld;
        disp_slot  = gnt_idx;
        disp_op    = ent_op[gnt_idx];
        disp_mem   = ent_mem[gnt_idx];
        disp_a     = a_data[gnt_idx];
        disp_b     = b_data[gnt_idx];
        disp_dst   = ent_dst[gnt_idx];
    end

    p_retire_after_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_slot == head && ent_vld[head] && !cmt_valid && !flush)
        |=> cmt_valid);
    p_dispatch_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !flush) |=> !(disp_valid && disp_slot == $past(disp_slot)));
    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (alloc_ready && !cmt_valid && !disp_valid));
    p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !pop && !flush) |=> !alloc_ready);

endmodule

// File: tb/tb_commit_window.sv
`timescale 1ns/1ps
module tb_commit_window;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        alloc_valid = 1'b0;
    logic        alloc_ready;
    logic [2:0]  alloc_slot;
    logic [15:0] alloc_pc = '0;
    logic [3:0]  alloc_op = '0;
    logic        alloc_mem = 1'b0;
    logic [7:0]  alloc_dst = '0;
    logic        alloc_a_rdy = 1'b0;
    logic [7:0]  alloc_a_tag = '0;
    logic [15:0] alloc_a_data = '0;
    logic        alloc_b_rdy = 1'b0;
    logic [7:0]  alloc_b_tag = '0;
    logic [15:0] alloc_b_data = '0;
    logic        disp_valid;
    logic        disp_ready = 1'b0;
    logic [2:0]  disp_slot;
    logic [3:0]  disp_op;
    logic        disp_mem;
    logic [15:0] disp_a;
    logic [15:0] disp_b;
    logic [7:0]  disp_dst;
    logic        res_valid = 1'b0;
    logic [2:0]  res_slot = '0;
    logic [7:0]  res_tag = '0;
    logic [15:0] res_data = '0;
    logic        cmt_valid;
    logic [7:0]  cmt_tag;
    logic [15:0] cmt_data;
    logic [15:0] cmt_pc;

    always #2.5 clk = ~clk;

    commit_window dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
        .alloc_pc(alloc_pc), .alloc_op(alloc_op), .alloc_mem(alloc_mem), .alloc_dst(alloc_dst),
        .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag), .alloc_a_data(alloc_a_data),
        .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag), .alloc_b_data(alloc_b_data),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_slot(disp_slot),
        .disp_op(disp_op), .disp_mem(disp_mem), .disp_a(disp_a), .disp_b(disp_b),
        .disp_dst(disp_dst),
        .res_valid(res_valid), .res_slot(res_slot), .res_tag(res_tag), .res_data(res_data),
        .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_data(cmt_data), .cmt_pc(cmt_pc)
    );

    // Behavioural model: a program-ordered queue of in-flight instructions.
    typedef struct {
        int slot; int pc; int op; bit mem; int dst;
        bit ar; int at; int ad;
        bit br; int bt; int bd;
        bit sent; bit exe; int val;
    } ent_t;

    ent_t q[$];
    int   nslot = 0;
    int   nseq  = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pick_slot();
        int mi = -1;
        int ai = -1;
        for (int i = 0; i < q.size(); i++) begin
            if (!q[i].sent && q[i].ar && q[i].br) begin
                if (ai < 0) ai = i;
                if (q[i].mem && mi < 0) mi = i;
            end
        end
        return (mi >= 0) ? mi : ai;
    endfunction

    task automatic check_empty(input string req);
        chk({req, " alloc_ready"}, alloc_ready, 1);
        chk({req, " cmt_valid"}, cmt_valid, 0);
        chk({req, " disp_valid"}, disp_valid, 0);
        chk({req, " alloc_slot"}, alloc_slot, 0);
    endtask

    initial begin
        bit prev_flush = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_empty("R1");
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int  phase = (cyc / 400) % 4;
            int  p_alloc;
            int  p_disp;
            int  p_res;
            int  p_mem;
            int  pk;
            bit  e_cmt;
            int  c_tag;
            int  c_data;
            bit  accept;
            int  pend[$];
            ent_t n;

            // Compare every output with the model state.
            if (prev_flush) check_empty("R11");
            pk    = pick_slot();
            e_cmt = (q.size() > 0) && q[0].exe;
            chk("R2 alloc_ready", alloc_ready, (q.size() < DEPTH) ? 1 : 0);
            chk("R2 alloc_slot", alloc_slot, nslot);
            chk("R3 cmt_valid", cmt_valid, e_cmt);
            if (e_cmt) begin
                chk("R4 cmt_tag", cmt_tag, q[0].dst);
                chk("R4 cmt_data", cmt_data, q[0].val);
                chk("R4 cmt_pc", cmt_pc, q[0].pc);
            end
            chk("R5 R6 disp_valid", disp_valid, (pk >= 0) ? 1 : 0);
            if (pk >= 0) begin
                chk("R7 disp_slot", disp_slot, q[pk].slot);
                chk("R7 disp_mem", disp_mem, q[pk].mem);
                chk("R5 disp_op", disp_op, q[pk].op);
                chk("R5 disp_dst", disp_dst, q[pk].dst);
                chk("R8 R9 R10 disp_a", disp_a, q[pk].ad);
                chk("R8 R9 R10 disp_b", disp_b, q[pk].bd);
            end

            // Drive stimulus for this cycle.
            case (phase)
                0:       begin p_alloc = 90; p_disp = 20; p_res = 30; p_mem = 20; end
                1:       begin p_alloc = 60; p_disp = 70; p_res = 60; p_mem = 20; end
                2:       begin p_alloc = 30; p_disp = 90; p_res = 80; p_mem = 20; end
                default: begin p_alloc = 70; p_disp = 60; p_res = 50; p_mem = 60; end
            endcase
            flush       = ($urandom_range(149) == 0);
            alloc_valid = ($urandom_range(99) < p_alloc);
            alloc_pc    = 16'($urandom);
            alloc_op    = 4'($urandom);
            alloc_mem   = ($urandom_range(99) < p_mem);
            alloc_dst   = 8'(nseq);
            alloc_a_rdy = 1'b1; alloc_a_tag = 8'($urandom); alloc_a_data = 16'($urandom);
            alloc_b_rdy = 1'b1; alloc_b_tag = 8'($urandom); alloc_b_data = 16'($urandom);
            if (q.size() > 0 && $urandom_range(1) == 1) begin
                alloc_a_rdy = 1'b0;
                alloc_a_tag = 8'(q[$urandom_range(q.size() - 1)].dst);
            end
            if (q.size() > 0 && $urandom_range(2) == 0) begin
                alloc_b_rdy = 1'b0;
                alloc_b_tag = 8'(q[$urandom_range(q.size() - 1)].dst);
            end
            disp_ready = ($urandom_range(99) < p_disp);
            for (int i = 0; i < q.size(); i++)
                if (q[i].sent && !q[i].exe) pend.push_back(i);
            res_valid = 1'b0;
            if (pend.size() > 0 && $urandom_range(99) < p_res) begin
                int j = pend[$urandom_range(pend.size() - 1)];
                res_valid = 1'b1;
                res_slot  = 3'(q[j].slot);
                res_tag   = 8'(q[j].dst);
                res_data  = 16'(q[j].ad + q[j].bd + q[j].op);
            end

            // Advance the model by one clock.
            if (flush) begin
                q.delete();       // R11: all uncommitted work dropped
                nslot = 0;
            end else begin
                c_tag  = e_cmt ? q[0].dst : -1;
                c_data = e_cmt ? q[0].val : 0;
                accept = alloc_valid && (q.size() < DEPTH);
                for (int i = 0; i < q.size(); i++) begin
                    if (!q[i].ar) begin
                        if (res_valid && q[i].at == int'(res_tag)) begin q[i].ar = 1; q[i].ad = res_data; end
                        else if (e_cmt && q[i].at == c_tag) begin q[i].ar = 1; q[i].ad = c_data; end
                    end
                    if (!q[i].br) begin
                        if (res_valid && q[i].bt == int'(res_tag)) begin q[i].br = 1; q[i].bd = res_data; end
                        else if (e_cmt && q[i].bt == c_tag) begin q[i].br = 1; q[i].bd = c_data; end
                    end
                    if (res_valid && q[i].slot == int'(res_slot)) begin
                        q[i].exe = 1; q[i].val = res_data;
                    end
                end
                if (pk >= 0 && disp_ready) q[pk].sent = 1;   // R6: marked once
                if (e_cmt) void'(q.pop_front());
                if (accept) begin
                    n.slot = nslot; n.pc = alloc_pc; n.op = alloc_op; n.mem = alloc_mem;
                    n.dst = alloc_dst; n.sent = 0; n.exe = 0; n.val = 0;
                    n.ar = alloc_a_rdy; n.at = alloc_a_tag; n.ad = alloc_a_data;
                    n.br = alloc_b_rdy; n.bt = alloc_b_tag; n.bd = alloc_b_data;
                    // R10: same-cycle capture at allocation
                    if (!n.ar && res_valid && n.at == int'(res_tag)) begin n.ar = 1; n.ad = res_data; end
                    else if (!n.ar && e_cmt && n.at == c_tag) begin n.ar = 1; n.ad = c_data; end
                    if (!n.br && res_valid && n.bt == int'(res_tag)) begin n.br = 1; n.bd = res_data; end
                    else if (!n.br && e_cmt && n.bt == c_tag) begin n.br = 1; n.bd = c_data; end
                    q.push_back(n);
                    nslot = (nslot + 1) % DEPTH;
                    nseq  = (nseq + 1) % 256;
                end
            end
            prev_flush = flush;
            @(negedge clk);
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule